// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts processor activity for profiling. It holds one cycle counter and four 32-bit event counters. Each event counter watches one line of a 256-wide event strobe vector, chosen by an 8-bit code. A simple register bus writes and reads a control word, the event-select word, an interrupt-enable mask, a sticky overflow-flag word and all five counters.

Software uses it by sampling. It preloads a counter with the two's-complement negative of a sample interval N, picks an event and sets the global enable. After N events the counter wraps from all-ones to zero. The wrap sets that counter's overflow flag. If the matching enable bit is set, the level interrupt rises. The handler clears the flag by writing a one to it and reloads the counter. The cycle counter can optionally advance only once every 64 clocks.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 (global enable) is 0, no counter changes except through a bus write. While it is 1, the counters advance as R3 and R5 describe.
- R2: Writing control with bit 1 set zeroes all four event counters. Writing control with bit 2 set zeroes the cycle counter and the divide-by-64 prescaler. Neither bit is stored, and both always read as 0.
- R3: With control bit 3 set, the cycle counter advances on every 64th enabled clock, counted from its last clear. With bit 3 clear, it advances on every enabled clock.
- R4: A control read returns the enable in bit 0, the divide mode in bit 3 and the constant ID_CODE (default 0x24) in bits 31:24. All other bits read 0. Writes to bits 31:24 have no effect.
- R5: Event-select bits 7:0, 15:8, 23:16 and 31:24 hold the codes for event counters 0, 1, 2 and 3. An enabled event counter adds one on each clock where event_in[code] is 1. The register reads back as written.
- R6: An event counter whose code is 0xFF never increments.
- R7: The interrupt-enable and overflow-flag registers use the same layout: bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. Bits 31:5 read 0.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag. Writing a 1 to a flag bit clears it, and writing a 0 leaves it as it was.
- R9: A bus write loads any 32-bit value into a counter. A preload of -N makes the counter wrap on the N-th counted event.
- R10: irq_out is 1 exactly while some overflow flag and its enable bit are both 1, whatever the global enable is.
- R11: When a counter write and an increment of that counter fall in the same clock, the written value is kept. When a flag-clear write and a new overflow of that flag fall in the same clock, the flag ends up set.
- R12: Synchronous reset zeroes every register, counter and the prescaler.
- R13: The address map is: 0 control, 1 event select, 2 interrupt enable, 3 overflow flags, 4 cycle counter, 5 to 8 event counters 0 to 3. bus_rdata is loaded on the clock where bus_re is 1, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| event_in | input | 256 | Event strobes, one per event code |
| irq_out | output | 1 | Level overflow interrupt |

## Verification
The hardest cases to reach from the ports are the two same-clock collisions. One is a counter write landing on the very clock where that counter would step. The other is a flag-clear write landing on the very clock where the counter wraps. The bench reaches both by starting the enable with one write and issuing the colliding write on the next bus cycle. For the wrap case, it preloads the counter with 0xFFFFFFFF so that the first enabled clock is the wrap. The divide-by-64 case is reached by running 200 enabled clocks from a cleared prescaler, which must give exactly three cycle-counter steps.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_EVSEL = 4'd1,
    A_IEN   = 4'd2,
    A_OVF   = 4'd3,
    A_CYC   = 4'd4
  } reg_addr_e;

  // control word bit positions
  localparam int C_EN     = 0;
  localparam int C_CLR_EV = 1;
  localparam int C_CLR_CY = 2;
  localparam int C_DIV    = 3;
endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic div_mode,
  output logic tick
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (run)   div_q <= div_q + 1'b1;
  end

  assign tick = run && (!div_mode || (&div_q));

  // in divide mode two ticks are never adjacent
  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div_mode) |=> (!tick || !div_mode)); // R3
endmodule

// File: rtl/pmu_event_pick.sv
module pmu_event_pick #(
  parameter int SEL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [(1<<SEL_W)-1:0]   event_in,
  input  logic [SEL_W-1:0]        sel,
  output logic                    hit
);
  assign hit = (sel != {SEL_W{1'b1}}) && event_in[sel];

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (rst)
    (sel == {SEL_W{1'b1}}) |-> !hit); // R6
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (ld)    cnt <= ld_val;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // wrap only when the increment actually lands
  assign wrap = inc && !ld && !clr && (&cnt);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (cnt == $past(ld_val))); // R11
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R2
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int         NUM_EVCNT = 4,
  parameter int         SEL_W     = 8,
  parameter int         PRESC_W   = 6,
  parameter logic [7:0] ID_CODE   = 8'h24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [(1<<SEL_W)-1:0] event_in,
  output logic                  irq_out
);
  localparam int NCNT = NUM_EVCNT + 1;

  logic              en_q, div_q;
  logic [DATA_W-1:0] evsel_q;
  logic [NCNT-1:0]   ien_q, ovf_q;
  logic [DATA_W-1:0] cnt_q [NCNT];
  logic [NCNT-1:0]   inc_v, wrap_v, ld_v;
  logic              wr_ctrl, clr_ev, clr_cy, cyc_tick;
  logic [NCNT-1:0]   flag_clr;
  logic [DATA_W-1:0] cnt_rd, rdata_q;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign clr_ev   = wr_ctrl && bus_wdata[C_CLR_EV];
  assign clr_cy   = wr_ctrl && bus_wdata[C_CLR_CY];
  assign flag_clr = (bus_we && bus_addr == A_OVF) ? bus_wdata[NCNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      evsel_q <= '0;
      ien_q   <= '0;
      ovf_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[C_EN];
        div_q <= bus_wdata[C_DIV];
      end
      if (bus_we && bus_addr == A_EVSEL) evsel_q <= bus_wdata;
      if (bus_we && bus_addr == A_IEN)   ien_q   <= bus_wdata[NCNT-1:0];
      // a new wrap beats a simultaneous clear
      ovf_q <= (ovf_q & ~flag_clr) | wrap_v;
    end
  end

  pmu_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .clr(clr_cy), .run(en_q),
    .div_mode(div_q), .tick(cyc_tick)
  );

  assign inc_v[0] = cyc_tick;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_CYC) + i);
    assign ld_v[i] = bus_we && (bus_addr == MY_ADDR);

    if (i > 0) begin : g_ev
      logic hit;
      pmu_event_pick #(.SEL_W(SEL_W)) u_pick (
        .clk(clk), .rst(rst), .event_in(event_in),
        .sel(evsel_q[(i-1)*SEL_W +: SEL_W]), .hit(hit)
      );
      assign inc_v[i] = en_q && hit;
    end

    pmu_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .clr((i == 0) ? clr_cy : clr_ev),
      .ld(ld_v[i]), .ld_val(bus_wdata), .inc(inc_v[i]),
      .cnt(cnt_q[i]), .wrap(wrap_v[i])
    );

    AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !bus_we) |=> $stable(cnt_q[i])); // R1
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
      wrap_v[i] |=> ovf_q[i]); // R8
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (ovf_q[i] && ien_q[i] && !bus_we) |=> irq_out); // R10
  end

  always_comb begin
    cnt_rd = '0;
    for (int i = 0; i < NCNT; i++)
      if (bus_addr == ADDR_W'(int'(A_CYC) + i)) cnt_rd = cnt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_re) begin
      case (bus_addr)
        A_CTRL:  rdata_q <= {ID_CODE, 20'b0, div_q, 2'b0, en_q};
        A_EVSEL: rdata_q <= evsel_q;
        A_IEN:   rdata_q <= {{(DATA_W-NCNT){1'b0}}, ien_q};
        A_OVF:   rdata_q <= {{(DATA_W-NCNT){1'b0}}, ovf_q};
        default: rdata_q <= cnt_rd;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = |(ovf_q & ien_q);
endmodule

// File: tb/sim_perf_mon_unit.sv
module sim_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] event_in = '0;
  logic        irq_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  perf_mon_unit u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .event_in(event_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // enable, wait extra clocks, disable: counts extra+1 enabled clocks
  task automatic run_en(input logic [31:0] ctrl_on, input int extra);
    wr(4'd0, ctrl_on);
    repeat (extra) @(negedge clk);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_reset;
    rchk("R12 ctrl after reset (R4 id)", 4'd0, 32'h2400_0000);
    rchk("R12 evsel after reset", 4'd1, 32'h0);
    rchk("R12 ien after reset", 4'd2, 32'h0);
    rchk("R12 ovf after reset", 4'd3, 32'h0);
    rchk("R12 cycle counter after reset", 4'd4, 32'h0);
    rchk("R12 event counter 3 after reset", 4'd8, 32'h0);
    chk("R12 irq after reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_ctrl_fields;
    wr(4'd0, 32'hFFFF_FFFF);
    rchk("R4 ctrl format, R2 reset bits read zero", 4'd0, 32'h2400_0009);
    wr(4'd0, 32'h0);
    rchk("R4 ctrl cleared", 4'd0, 32'h2400_0000);
    wr(4'd2, 32'hFFFF_FFFF);
    rchk("R7 ien width", 4'd2, 32'h0000_001F);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_count;
    wr(4'd1, 32'hFFC8_0703);
    rchk("R5 evsel readback", 4'd1, 32'hFFC8_0703);
    event_in[3] = 1'b1; event_in[200] = 1'b1; event_in[255] = 1'b1;
    wr(4'd0, 32'h6);
    run_en(32'h1, 19);
    rchk("R1 cycle counter enabled clocks", 4'd4, 32'd20);
    rchk("R5 counter0 on event 3", 4'd5, 32'd20);
    rchk("R5 counter1 idle event 7", 4'd6, 32'd0);
    rchk("R5 counter2 on event 200", 4'd7, 32'd20);
    rchk("R6 code 0xFF never counts", 4'd8, 32'd0);
  endtask

  task automatic t_disabled;
    repeat (10) @(negedge clk);
    rchk("R1 counter0 frozen when disabled", 4'd5, 32'd20);
    rchk("R1 cycle frozen when disabled", 4'd4, 32'd20);
  endtask

  task automatic t_reset_bits;
    wr(4'd0, 32'h2);
    rchk("R2 event clear counter0", 4'd5, 32'd0);
    rchk("R2 event clear counter2", 4'd7, 32'd0);
    rchk("R2 event clear spares cycle", 4'd4, 32'd20);
    wr(4'd0, 32'h4);
    rchk("R2 cycle clear", 4'd4, 32'd0);
  endtask

  task automatic t_div64;
    run_en(32'hD, 199);
    rchk("R3 divide-by-64 over 200 clocks", 4'd4, 32'd3);
  endtask

  task automatic t_overflow;
    event_in[7] = 1'b1;
    wr(4'd2, 32'h4);
    wr(4'd6, 32'hFFFF_FFFD);
    run_en(32'h1, 2);
    rchk("R9 preload -3 wraps after 3", 4'd6, 32'd0);
    rchk("R8 R7 flag bit 2 set", 4'd3, 32'h4);
    chk("R10 irq high while disabled", {31'b0, irq_out}, 32'd1);
    wr(4'd3, 32'h0);
    rchk("R8 writing 0 keeps flag", 4'd3, 32'h4);
    wr(4'd2, 32'h0);
    chk("R10 irq masked", {31'b0, irq_out}, 32'd0);
    wr(4'd2, 32'h4);
    chk("R10 irq unmasked", {31'b0, irq_out}, 32'd1);
    wr(4'd3, 32'h4);
    rchk("R8 write 1 clears flag", 4'd3, 32'h0);
    chk("R10 irq drops after clear", {31'b0, irq_out}, 32'd0);
  endtask

  task automatic t_collide;
    wr(4'd0, 32'h1);
    wr(4'd5, 32'h100);
    wr(4'd0, 32'h0);
    rchk("R11 write beats increment", 4'd5, 32'h101);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h4);
    wr(4'd0, 32'h0);
    rchk("R11 wrap beats flag clear", 4'd3, 32'h4);
    rchk("R11 counter1 after wrap", 4'd6, 32'd1);
  endtask

  task automatic t_unmapped;
    rchk("R13 unmapped reads zero", 4'hF, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_count();
    t_disabled();
    t_reset_bits();
    t_div64();
    t_overflow();
    t_collide();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule